// File: doc/BRIEF.md
# Reorder Buffer with Precise Exception Rollback

This block keeps the program order of every instruction between dispatch and completion in an out-of-order core. Up to two instructions per cycle are written at the tail of a circular store of eight entries. Each entry records the instruction address, the destination mapping that the instruction replaced, and flags marking it as a store and as speculative. Execution units later report an entry index with a fault flag. Finished entries leave from the head in program order, up to two per cycle. The oldest entry that is not finished, or that has faulted, stops the group.

A fault is only acted on once its entry reaches the head, so every older instruction has already left. In that cycle the block raises a flush pulse carrying the faulting address. It then runs a rollback walk. The walk goes one entry per cycle from the youngest entry back to the faulting one and hands each saved previous mapping to the rename logic. Dispatch is held off for the whole walk. A done pulse marks the last restored entry.

The control is a two-state machine. `ST_RUN` is normal dispatch and completion. The transition `ST_RUN -> ST_WALK` is taken when the head entry is finished and faulted. `ST_WALK` stays put while older entries remain. `ST_WALK -> ST_RUN` is taken when the walk restores the head entry, which leaves the buffer empty.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty. `disp_stall`, `cmpl_valid`, `exc_flush`, `rb_valid` and `rb_done` are all low, and `alloc_idx` is 0.
- R2: Accepted dispatch lanes take consecutive entry indices starting at `alloc_idx`, in lane order. `alloc_idx` advances by the number accepted, modulo 8.
- R3: `disp_stall` is high when fewer than two entries are free, in the cycle a fault is taken, and throughout the rollback walk. While it is high, dispatch requests are dropped and leave `alloc_idx` unchanged.
- R4: A finish report marks its entry finished and records its fault flag. A report aimed at an idle entry, or one that arrives during the walk, has no effect: a later instruction placed in that entry still waits for its own report.
- R5: Up to two entries leave per cycle, in program order. Lane 1 is valid only when lane 0 is valid. Leaving stops at the first entry that is unfinished or faulted. Each lane presents the address, previous mapping, store flag and speculative flag that were dispatched with it.
- R6: A faulted entry is acted on only at the head. In that cycle `exc_flush` is high for one cycle with `exc_pc` set to that entry's address, and no lane completes.
- R7: In the cycle after the flush, `rb_valid` presents one saved previous mapping per cycle on `rb_prev`. The walk starts at the youngest entry and ends at the faulting entry, with no gaps.
- R8: `rb_done` is high with the faulting entry's mapping. In the next cycle the walk is over and the buffer is empty and accepting dispatch.
- R9: All eight entries can be occupied. An extra wrap bit on each pointer tells a full buffer apart from an empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | DISP_W | Dispatch request per lane |
| disp_pc | input | DISP_W*ADDR_W | Instruction address per lane |
| disp_prev | input | DISP_W*MAP_W | Previous destination mapping per lane |
| disp_store | input | DISP_W | Store flag per lane |
| disp_spec | input | DISP_W | Speculative flag per lane |
| disp_stall | output | 1 | Dispatch not accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Entry index given to the first accepted lane |
| fin_valid | input | 1 | Finish report valid |
| fin_idx | input | log2(DEPTH) | Entry index of the finish report |
| fin_exc | input | 1 | The reported instruction faulted |
| cmpl_valid | output | CMPL_W | Completion per lane, lane 0 oldest |
| cmpl_pc | output | CMPL_W*ADDR_W | Address of each completing entry |
| cmpl_prev | output | CMPL_W*MAP_W | Previous mapping, freed on completion |
| cmpl_store | output | CMPL_W | Store flag of each completing entry |
| cmpl_spec | output | CMPL_W | Speculative flag of each completing entry |
| exc_flush | output | 1 | Fault taken at the head this cycle |
| exc_pc | output | ADDR_W | Address of the faulting entry |
| rb_valid | output | 1 | Rollback mapping valid |
| rb_prev | output | MAP_W | Mapping to restore into the rename table |
| rb_done | output | 1 | Last mapping of the rollback walk |

## Verification
The hardest state to reach from the ports is a fault on an entry that sits behind older finished entries after both pointers have wrapped. In that state, the walk must cross index 0 from the youngest entry back to the head. The stimulus gets there by first filling and draining the buffer, then filling it to eight entries so the tail wraps. It finishes the two oldest entries out of order, and then reports a fault on the entry at the new head. Younger entries are still present at that point, so the walk has to cross index 0. A second, single-entry fault checks the case where the walk begins and ends in the same cycle. A stale report aimed at an idle slot, followed by reuse of that slot, shows that finish reports are gated by occupancy.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_WALK = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int DISP_W = 2,
    parameter int ADDR_W = 32,
    parameter int MAP_W  = 6,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DISP_W-1:0]        wr_en,
    input  logic [IDX_W-1:0]         wr_idx [DISP_W],
    input  logic [DISP_W*ADDR_W-1:0] wr_pc,
    input  logic [DISP_W*MAP_W-1:0]  wr_prev,
    input  logic [DISP_W-1:0]        wr_store,
    input  logic [DISP_W-1:0]        wr_spec,
    input  logic                     fin_en,
    input  logic [IDX_W-1:0]         fin_idx,
    input  logic                     fin_exc,
    input  logic [DEPTH-1:0]         clr_mask,
    output logic [DEPTH-1:0]         busy,
    output logic [DEPTH-1:0]         fin,
    output logic [DEPTH-1:0]         exc,
    output logic [DEPTH-1:0]         st_flag,
    output logic [DEPTH-1:0]         spec_flag,
    output logic [ADDR_W-1:0]        pc   [DEPTH],
    output logic [MAP_W-1:0]         prev [DEPTH]
);

    // Status bits: clear on leave/rollback, set on allocation, update on finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            fin  <= '0;
            exc  <= '0;
        end else begin
            busy <= busy & ~clr_mask;
            fin  <= fin & ~clr_mask;
            exc  <= exc & ~clr_mask;
            for (int i = 0; i < DISP_W; i++) begin
                if (wr_en[i]) begin
                    busy[wr_idx[i]] <= 1'b1;
                    fin[wr_idx[i]]  <= 1'b0;
                    exc[wr_idx[i]]  <= 1'b0;
                end
            end
            if (fin_en && busy[fin_idx]) begin
                fin[fin_idx] <= 1'b1;
                exc[fin_idx] <= fin_exc;
            end
        end
    end

    // Payload: written at allocation only
    always_ff @(posedge clk) begin
        for (int i = 0; i < DISP_W; i++) begin
            if (wr_en[i]) begin
                pc[wr_idx[i]]        <= wr_pc[i*ADDR_W +: ADDR_W];
                prev[wr_idx[i]]      <= wr_prev[i*MAP_W +: MAP_W];
                st_flag[wr_idx[i]]   <= wr_store[i];
                spec_flag[wr_idx[i]] <= wr_spec[i];
            end
        end
    end

endmodule

// File: rtl/rob_cmpl_sel.sv
module rob_cmpl_sel #(
    parameter int DEPTH  = 8,
    parameter int CMPL_W = 2,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PTR_W  = IDX_W + 1
) (
    input  logic              run,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [PTR_W-1:0]  count,
    input  logic [DEPTH-1:0]  busy,
    input  logic [DEPTH-1:0]  fin,
    input  logic [DEPTH-1:0]  exc,
    output logic [CMPL_W-1:0] lane_ok,
    output logic              head_fault
);

    logic [CMPL_W-1:0] chain;

    assign chain[0] = run;

    for (genvar k = 0; k < CMPL_W; k++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx = head_idx + IDX_W'(k);
        assign lane_ok[k] = chain[k] & (count > PTR_W'(k))
                          & busy[idx] & fin[idx] & ~exc[idx];
        if (k + 1 < CMPL_W) begin : g_next
            assign chain[k+1] = lane_ok[k];
        end
    end

    assign head_fault = run & (count != '0)
                      & busy[head_idx] & fin[head_idx] & exc[head_idx];

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DISP_W = 2,
    parameter int CMPL_W = 2,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PTR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DISP_W-1:0] disp_valid,
    input  logic [CMPL_W-1:0] lane_ok,
    input  logic              head_fault,
    output logic [IDX_W-1:0]  head_idx,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [PTR_W-1:0]  count,
    output logic              run,
    output logic              disp_stall,
    output logic [DISP_W-1:0] wr_en,
    output logic [IDX_W-1:0]  wr_idx [DISP_W],
    output logic [DEPTH-1:0]  clr_mask,
    output logic              exc_flush,
    output logic              rb_valid,
    output logic              rb_done,
    output logic [IDX_W-1:0]  rb_idx
);

    localparam logic [PTR_W-1:0] STALL_LVL = PTR_W'(DEPTH - DISP_W);

    rob_state_e       st_q, st_d;
    logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [PTR_W-1:0] tail_m1;
    logic [PTR_W-1:0] n_acc, n_cmpl;
    logic             walk_last;

    assign head_idx  = head_q[IDX_W-1:0];
    assign tail_idx  = tail_q[IDX_W-1:0];
    assign count     = tail_q - head_q;
    assign tail_m1   = tail_q - PTR_W'(1);
    assign walk_last = (tail_m1 == head_q);
    assign run       = (st_q == ST_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            st_q   <= st_d;
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    // Next state and pointers
    always_comb begin
        st_d   = st_q;
        head_d = head_q;
        tail_d = tail_q;
        unique case (st_q)
            ST_RUN: begin
                head_d = head_q + n_cmpl;
                tail_d = tail_q + n_acc;
                if (head_fault) st_d = ST_WALK;
            end
            ST_WALK: begin
                tail_d = tail_m1;
                if (walk_last) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        disp_stall = ~run | head_fault | (count > STALL_LVL);
        exc_flush  = head_fault;
        rb_valid   = (st_q == ST_WALK);
        rb_done    = rb_valid & walk_last;
        rb_idx     = tail_m1[IDX_W-1:0];
        n_acc      = '0;
        n_cmpl     = '0;
        clr_mask   = '0;
        for (int i = 0; i < DISP_W; i++) begin
            wr_en[i]  = disp_valid[i] & ~disp_stall;
            wr_idx[i] = tail_idx + n_acc[IDX_W-1:0];
            if (wr_en[i]) n_acc = n_acc + PTR_W'(1);
        end
        for (int k = 0; k < CMPL_W; k++) begin
            if (lane_ok[k]) begin
                clr_mask[IDX_W'(head_idx + IDX_W'(k))] = 1'b1;
                n_cmpl = n_cmpl + PTR_W'(1);
            end
        end
        if (rb_valid) clr_mask[rb_idx] = 1'b1;
    end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
    parameter int DEPTH  = 8,
    parameter int DISP_W = 2,
    parameter int CMPL_W = 2,
    parameter int ADDR_W = 32,
    parameter int MAP_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DISP_W-1:0]          disp_valid,
    input  logic [DISP_W*ADDR_W-1:0]   disp_pc,
    input  logic [DISP_W*MAP_W-1:0]    disp_prev,
    input  logic [DISP_W-1:0]          disp_store,
    input  logic [DISP_W-1:0]          disp_spec,
    output logic                       disp_stall,
    output logic [$clog2(DEPTH)-1:0]   alloc_idx,
    input  logic                       fin_valid,
    input  logic [$clog2(DEPTH)-1:0]   fin_idx,
    input  logic                       fin_exc,
    output logic [CMPL_W-1:0]          cmpl_valid,
    output logic [CMPL_W*ADDR_W-1:0]   cmpl_pc,
    output logic [CMPL_W*MAP_W-1:0]    cmpl_prev,
    output logic [CMPL_W-1:0]          cmpl_store,
    output logic [CMPL_W-1:0]          cmpl_spec,
    output logic                       exc_flush,
    output logic [ADDR_W-1:0]          exc_pc,
    output logic                       rb_valid,
    output logic [MAP_W-1:0]           rb_prev,
    output logic                       rb_done
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [IDX_W-1:0]  head_idx, tail_idx, rb_idx;
    logic [PTR_W-1:0]  count;
    logic              run, head_fault;
    logic [DISP_W-1:0] wr_en;
    logic [IDX_W-1:0]  wr_idx [DISP_W];
    logic [DEPTH-1:0]  clr_mask, busy, fin, exc, st_flag, spec_flag;
    logic [ADDR_W-1:0] pc   [DEPTH];
    logic [MAP_W-1:0]  prev [DEPTH];
    logic [CMPL_W-1:0] lane_ok;

    rob_ctrl #(
        .DEPTH(DEPTH), .DISP_W(DISP_W), .CMPL_W(CMPL_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_valid (disp_valid),
        .lane_ok    (lane_ok),
        .head_fault (head_fault),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx),
        .count      (count),
        .run        (run),
        .disp_stall (disp_stall),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .clr_mask   (clr_mask),
        .exc_flush  (exc_flush),
        .rb_valid   (rb_valid),
        .rb_done    (rb_done),
        .rb_idx     (rb_idx)
    );

    rob_store #(
        .DEPTH(DEPTH), .DISP_W(DISP_W), .ADDR_W(ADDR_W), .MAP_W(MAP_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_pc     (disp_pc),
        .wr_prev   (disp_prev),
        .wr_store  (disp_store),
        .wr_spec   (disp_spec),
        .fin_en    (fin_valid & run),
        .fin_idx   (fin_idx),
        .fin_exc   (fin_exc),
        .clr_mask  (clr_mask),
        .busy      (busy),
        .fin       (fin),
        .exc       (exc),
        .st_flag   (st_flag),
        .spec_flag (spec_flag),
        .pc        (pc),
        .prev      (prev)
    );

    rob_cmpl_sel #(
        .DEPTH(DEPTH), .CMPL_W(CMPL_W)
    ) sel_i (
        .run        (run),
        .head_idx   (head_idx),
        .count      (count),
        .busy       (busy),
        .fin        (fin),
        .exc        (exc),
        .lane_ok    (lane_ok),
        .head_fault (head_fault)
    );

    for (genvar k = 0; k < CMPL_W; k++) begin : g_out
        logic [IDX_W-1:0] idx;
        assign idx                           = head_idx + IDX_W'(k);
        assign cmpl_valid[k]                 = lane_ok[k];
        assign cmpl_pc[k*ADDR_W +: ADDR_W]   = pc[idx];
        assign cmpl_prev[k*MAP_W +: MAP_W]   = prev[idx];
        assign cmpl_store[k]                 = st_flag[idx];
        assign cmpl_spec[k]                  = spec_flag[idx];
    end

    assign alloc_idx = tail_idx;
    assign exc_pc    = pc[head_idx];
    assign rb_prev   = prev[rb_idx];

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int CMPL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_stall,
    input logic [CMPL_W-1:0] cmpl_valid,
    input logic              exc_flush,
    input logic              rb_valid,
    input logic              rb_done
);

    // R5: lanes complete as a prefix
    for (genvar k = 1; k < CMPL_W; k++) begin : g_pfx
        a_r5_lane_prefix: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl_valid[k] |-> cmpl_valid[k-1]);
    end

    // R6: no lane completes in the cycle a fault is taken
    a_r6_flush_no_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flush |-> (cmpl_valid == '0));

    // R7: the walk starts right after the flush
    a_r7_walk_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flush |=> rb_valid);

    // R7: the walk has no gaps until done
    a_r7_walk_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_valid && !rb_done) |=> rb_valid);

    // R3: dispatch is held during the walk
    a_r3_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> disp_stall);

    // R8: done marks a walk cycle, and the buffer accepts afterwards
    a_r8_done_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_done |-> rb_valid);

    a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
        rb_done |=> (!rb_valid && !disp_stall));

endmodule

bind reorder_buffer rob_checker #(.CMPL_W(CMPL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_stall (disp_stall),
    .cmpl_valid (cmpl_valid),
    .exc_flush  (exc_flush),
    .rb_valid   (rb_valid),
    .rb_done    (rb_done)
);

// File: tb/reorder_buffer_tb_top.sv
module reorder_buffer_tb_top;

    localparam int DEPTH  = 8;
    localparam int DISP_W = 2;
    localparam int CMPL_W = 2;
    localparam int ADDR_W = 32;
    localparam int MAP_W  = 6;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [DISP_W-1:0]        disp_valid;
    logic [DISP_W*ADDR_W-1:0] disp_pc;
    logic [DISP_W*MAP_W-1:0]  disp_prev;
    logic [DISP_W-1:0]        disp_store, disp_spec;
    logic                     disp_stall;
    logic [2:0]               alloc_idx;
    logic                     fin_valid;
    logic [2:0]               fin_idx;
    logic                     fin_exc;
    logic [CMPL_W-1:0]        cmpl_valid;
    logic [CMPL_W*ADDR_W-1:0] cmpl_pc;
    logic [CMPL_W*MAP_W-1:0]  cmpl_prev;
    logic [CMPL_W-1:0]        cmpl_store, cmpl_spec;
    logic                     exc_flush;
    logic [ADDR_W-1:0]        exc_pc;
    logic                     rb_valid;
    logic [MAP_W-1:0]         rb_prev;
    logic                     rb_done;

    always #2 clk = ~clk;

    reorder_buffer #(
        .DEPTH(DEPTH), .DISP_W(DISP_W), .CMPL_W(CMPL_W),
        .ADDR_W(ADDR_W), .MAP_W(MAP_W)
    ) dut_i (.*);

    int  n_chk = 0;
    int  n_err = 0;
    bit  done_flag = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // dv: dispatch lanes, fv/fi/fx: finish report,
    // nc: completions, st: stall, fl: flush, rv/rd/rp: rollback, ai: alloc index
    typedef struct packed {
        logic [1:0] dv; logic fv; logic [2:0] fi; logic fx;
        logic [1:0] nc; logic st; logic fl; logic rv; logic rd;
        logic [4:0] rp; logic [2:0] ai;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t TBL [NV] = '{
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 0  R2
        '{2'b11,1'b1,3'd1,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd2}, // 1
        '{2'b00,1'b1,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 2
        '{2'b00,1'b1,3'd3,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 3  R5 stops at idx2
        '{2'b00,1'b1,3'd2,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 4
        '{2'b00,1'b0,3'd0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 5
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 6
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd6}, // 7
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 8  tail wraps
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd2}, // 9  R9 fills to 8
        '{2'b11,1'b1,3'd5,1'b0, 2'd0,1'b1,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 10 R3 full, dropped
        '{2'b00,1'b1,3'd4,1'b0, 2'd0,1'b1,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 11
        '{2'b00,1'b0,3'd0,1'b0, 2'd2,1'b1,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 12
        '{2'b00,1'b1,3'd7,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 13
        '{2'b00,1'b1,3'd6,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd4}, // 14
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b1,1'b0,1'b0,5'd0, 3'd4}, // 15 R6 flush
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,5'd11,3'd4}, // 16 R7 walk
        '{2'b00,1'b1,3'd1,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,5'd10,3'd3}, // 17 R4 ignored
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,5'd9, 3'd2}, // 18
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,5'd8, 3'd1}, // 19
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b0,5'd7, 3'd0}, // 20
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b1,5'd6, 3'd7}, // 21 R8 done
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd6}, // 22
        '{2'b00,1'b1,3'd7,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 23
        '{2'b00,1'b1,3'd6,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 24
        '{2'b00,1'b0,3'd0,1'b0, 2'd2,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 25
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd0}, // 26
        '{2'b00,1'b1,3'd1,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd2}, // 27 fault off head
        '{2'b00,1'b1,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd2}, // 28 R6 not yet
        '{2'b00,1'b0,3'd0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd2}, // 29 R5 stops at fault
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b1,1'b0,1'b0,5'd0, 3'd2}, // 30
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b1,1'b0,1'b1,1'b1,5'd15,3'd2}, // 31 one-entry walk
        '{2'b00,1'b1,3'd5,1'b1, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd1}, // 32 R4 idle slot
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd1}, // 33
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd3}, // 34
        '{2'b11,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd5}, // 35 reuses idx5
        '{2'b00,1'b1,3'd1,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}, // 36
        '{2'b00,1'b1,3'd2,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}, // 37
        '{2'b00,1'b1,3'd3,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}, // 38
        '{2'b00,1'b1,3'd4,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}, // 39
        '{2'b00,1'b0,3'd0,1'b0, 2'd1,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}, // 40
        '{2'b00,1'b0,3'd0,1'b0, 2'd0,1'b0,1'b0,1'b0,1'b0,5'd0, 3'd7}  // 41 R4 idx5 waits
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seq  = 0;
        int cseq = 0;
        rst_n      = 1'b0;
        disp_valid = '0;
        disp_pc    = '0;
        disp_prev  = '0;
        disp_store = '0;
        disp_spec  = '0;
        fin_valid  = 1'b0;
        fin_idx    = '0;
        fin_exc    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 stall",  disp_stall, 0);
        chk("R1 cmpl",   cmpl_valid, 0);
        chk("R1 flush",  exc_flush,  0);
        chk("R1 rb",     rb_valid,   0);
        chk("R1 done",   rb_done,    0);
        chk("R1 alloc",  alloc_idx,  0);

        for (int r = 0; r < NV; r++) begin
            vec_t v;
            v = TBL[r];
            @(negedge clk);
            disp_valid = v.dv;
            disp_pc    = {ADDR_W'((seq + 1) * 4), ADDR_W'(seq * 4)};
            disp_prev  = {MAP_W'(seq + 1), MAP_W'(seq)};
            disp_store = {1'((seq + 1) % 2), 1'(seq % 2)};
            disp_spec  = {1'(((seq + 1) >> 1) % 2), 1'((seq >> 1) % 2)};
            fin_valid  = v.fv;
            fin_idx    = v.fi;
            fin_exc    = v.fx;
            #1;
            chk($sformatf("R5 count row %0d", r), $countones(cmpl_valid), v.nc);
            chk($sformatf("R3 stall row %0d", r), disp_stall, v.st);
            chk($sformatf("R6 flush row %0d", r), exc_flush, v.fl);
            chk($sformatf("R7 rb valid row %0d", r), rb_valid, v.rv);
            chk($sformatf("R8 rb done row %0d", r), rb_done, v.rd);
            chk($sformatf("R2 alloc row %0d", r), alloc_idx, v.ai);
            if (v.rv)
                chk($sformatf("R7 rb prev row %0d", r), rb_prev, v.rp);
            if (exc_flush)
                chk($sformatf("R6 exc pc row %0d", r), exc_pc, cseq * 4);
            for (int k = 0; k < CMPL_W; k++) begin
                if (cmpl_valid[k]) begin
                    chk($sformatf("R5 pc row %0d lane %0d", r, k),
                        cmpl_pc[k*ADDR_W +: ADDR_W], (cseq + k) * 4);
                    chk($sformatf("R5 prev row %0d lane %0d", r, k),
                        cmpl_prev[k*MAP_W +: MAP_W], (cseq + k) % 64);
                    chk($sformatf("R5 store row %0d lane %0d", r, k),
                        cmpl_store[k], (cseq + k) % 2);
                    chk($sformatf("R5 spec row %0d lane %0d", r, k),
                        cmpl_spec[k], ((cseq + k) >> 1) % 2);
                end
            end
            if (!disp_stall) seq = seq + $countones(v.dv);
            cseq = cseq + $countones(cmpl_valid);
            if (rb_done) cseq = seq;
        end

        @(negedge clk);
        disp_valid = '0;
        fin_valid  = 1'b0;
        done_flag  = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule